// File: doc/BRIEF.md
# Programmable Duty-Cycle Delay Code Calculator

This block turns a measured clock period into the delay code that places the falling edge of a generated output clock. A time-to-digital measurement arrives as a thermometer word: the coarse and fine detector stages together set a run of ones, starting at bit 0, whose length is the input period in fine-delay steps. The block counts those ones to form a binary period code, where the full code stands for 100% duty.

From the period code it builds scaled copies by right shifts: half, quarter, eighth and sixteenth of the period, each rounded down. A 4-bit duty selection enables the copies to add up. Their sum is the delay code that picks the delay path whose pulse clears the output flip-flop. For example, half plus eighth gives about 62%, and quarter plus sixteenth gives about 31%. No table is used. The eighth and sixteenth terms share one adder input, so only one of them can be counted at a time, and the eighth wins.

A strobe marks each new measurement. The period code, the delay code and an error flag are registered, and they appear together one clock after the strobe. They then hold until the next strobe.

Top module: `dcyc_delay_calc`

## Requirements
- R1: After reset, `res_vld`, `per_code`, `dly_code` and `therm_err` are all zero.
- R2: `res_vld` is high for exactly the one cycle that follows each cycle in which `meas_vld` is high, and low otherwise.
- R3: For a legal thermometer word (all ones below any zero, the all-zero word included), `per_code` equals the number of ones in `meas_therm`.
- R4: `dly_code` is the sum of the enabled terms floor(P/2) (`duty_sel[3]`), floor(P/4) (`duty_sel[2]`), floor(P/8) (`duty_sel[1]`) and floor(P/16) (`duty_sel[0]`), where P is the period code. With `duty_sel` zero, `dly_code` is zero.
- R5: When `duty_sel[1]` and `duty_sel[0]` are both set, only the floor(P/8) term is added, and the floor(P/16) term is dropped.
- R6: A word that has a one above a zero is illegal. It gives `therm_err` = 1 with `per_code` = 0 and `dly_code` = 0. A legal word gives `therm_err` = 0.
- R7: While `meas_vld` stays low, `per_code`, `dly_code` and `therm_err` hold their values.
- R8: When `res_vld` is high, `dly_code` never exceeds `per_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_vld | input | 1 | Strobe: a new measurement is on `meas_therm` |
| meas_therm | input | 63 | Combined coarse/fine thermometer measurement |
| duty_sel | input | 4 | Term enables: bit3 half, bit2 quarter, bit1 eighth, bit0 sixteenth |
| res_vld | output | 1 | Result strobe, one cycle after `meas_vld` |
| per_code | output | 6 | Binary period code (count of ones) |
| dly_code | output | 6 | Delay code for the falling-edge path |
| therm_err | output | 1 | Measurement was not a legal thermometer word |

## Verification
The hardest inputs to reach are the ones where truncation changes the answer: periods that are not multiples of 16, combined with both eighth and sixteenth enabled, so that dropping the sixteenth term is visible. A uniformly random 63-bit word is almost never a legal thermometer word. For that reason the stimulus draws a random run length and builds the word from it. It then corrupts a minority of words with a stray bit to reach the error path. Directed cases add the empty word, the full word, a period of one, and every selection code at a period of 63.

// File: rtl/dcyc_delay_calc.sv
module dcyc_delay_calc #(
  parameter int CODE_W = 6,
  parameter int SEL_W  = 4,
  localparam int THERM_W = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_vld,
  input  logic [THERM_W-1:0] meas_therm,
  input  logic [SEL_W-1:0]   duty_sel,
  output logic               res_vld,
  output logic [CODE_W-1:0]  per_code,
  output logic [CODE_W-1:0]  dly_code,
  output logic               therm_err
);

  logic [CODE_W-1:0] ones_cnt;
  logic              therm_ok;
  logic [CODE_W-1:0] per_c;
  logic [CODE_W-1:0] t_half, t_qtr, t_shr;
  logic [CODE_W+1:0] sum_w;
  logic [CODE_W-1:0] dly_c;

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < THERM_W; i++)
      ones_cnt = ones_cnt + CODE_W'(meas_therm[i]);
  end

  assign therm_ok = ((meas_therm + THERM_W'(1)) & meas_therm) == '0;
  assign per_c    = therm_ok ? ones_cnt : '0;

  assign t_half = duty_sel[3] ? (per_c >> 1) : '0;
  assign t_qtr  = duty_sel[2] ? (per_c >> 2) : '0;
  assign t_shr  = duty_sel[1] ? (per_c >> 3) :
                  duty_sel[0] ? (per_c >> 4) : '0;

  assign sum_w = (CODE_W+2)'(t_half) + (CODE_W+2)'(t_qtr) + (CODE_W+2)'(t_shr);
  assign dly_c = (sum_w > (CODE_W+2)'(THERM_W)) ? CODE_W'(THERM_W) : sum_w[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      per_code  <= '0;
      dly_code  <= '0;
      therm_err <= 1'b0;
    end else begin
      res_vld <= meas_vld;
      if (meas_vld) begin
        per_code  <= per_c;
        dly_code  <= dly_c;
        therm_err <= ~therm_ok;
      end
    end
  end

endmodule

module dcyc_delay_calc_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_vld,
  input logic              res_vld,
  input logic [CODE_W-1:0] per_code,
  input logic [CODE_W-1:0] dly_code,
  input logic              therm_err
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> res_vld);
  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> !res_vld);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> ($stable(per_code) && $stable(dly_code) && $stable(therm_err)));
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_err |-> (per_code == '0 && dly_code == '0));
  // R8
  dly_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> dly_code <= per_code);
endmodule

bind dcyc_delay_calc dcyc_delay_calc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .res_vld(res_vld),
  .per_code(per_code), .dly_code(dly_code), .therm_err(therm_err));

// File: tb/dcyc_delay_calc_tb.sv
module dcyc_delay_calc_tb;
  localparam int CW = 6;
  localparam int TW = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas_vld = 1'b0;
  logic [TW-1:0] meas_therm = '0;
  logic [3:0]    duty_sel = '0;
  logic          res_vld;
  logic [CW-1:0] per_code, dly_code;
  logic          therm_err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dcyc_delay_calc u_dut (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_therm(meas_therm),
    .duty_sel(duty_sel), .res_vld(res_vld), .per_code(per_code),
    .dly_code(dly_code), .therm_err(therm_err));

  function automatic bit legal(input logic [TW-1:0] w);
    bit seen_zero = 0;
    for (int i = 0; i < TW; i++) begin
      if (!w[i]) seen_zero = 1;
      else if (seen_zero) return 0;
    end
    return 1;
  endfunction

  function automatic int exp_per(input logic [TW-1:0] w);
    int n = 0;
    if (!legal(w)) return 0;
    for (int i = 0; i < TW; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int exp_dly(input int p, input logic [3:0] s);
    int d = 0;
    if (s[3]) d += p / 2;
    if (s[2]) d += p / 4;
    if (s[1]) d += p / 8;
    else if (s[0]) d += p / 16;
    return d;
  endfunction

  function automatic logic [TW-1:0] therm_of(input int n);
    logic [63:0] v = (64'd1 << n) - 64'd1;
    return v[TW-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [TW-1:0] w, input logic [3:0] s, input string tag);
    int p, d;
    p = exp_per(w);
    d = exp_dly(p, s);
    @(negedge clk);
    meas_vld = 1'b1; meas_therm = w; duty_sel = s;
    @(negedge clk);
    meas_vld = 1'b0; meas_therm = ~w; duty_sel = ~s;
    chk({"R2 vld ", tag}, int'(res_vld), 1);
    chk({"R3 per ", tag}, int'(per_code), p);
    chk({"R4 dly ", tag}, int'(dly_code), d);
    chk({"R6 err ", tag}, int'(therm_err), legal(w) ? 0 : 1);
    chk({"R8 bound ", tag}, int'(dly_code <= per_code), 1);
    @(negedge clk);
    chk({"R2 low ", tag}, int'(res_vld), 0);
    chk({"R7 hold ", tag}, int'(dly_code), d);
    chk({"R7 hold per ", tag}, int'(per_code), p);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    #12;
    chk("R1 vld", int'(res_vld), 0);
    chk("R1 per", int'(per_code), 0);
    chk("R1 dly", int'(dly_code), 0);
    chk("R1 err", int'(therm_err), 0);
    rst_n = 1'b1;

    apply(therm_of(0), 4'b1111, "empty");
    apply(therm_of(63), 4'b1000, "full half");
    apply(therm_of(1), 4'b1000, "p1");
    apply(therm_of(40), 4'b0000, "R4 sel0");
    for (int s = 0; s < 16; s++) apply(therm_of(63), 4'(s), "R5 sweep");
    apply(therm_of(31), 4'b0011, "R5 both");
    apply(therm_of(31), 4'b0001, "R4 sixteenth");
    apply(therm_of(47), 4'b0101, "R4 q+s");
    apply(63'b10, 4'b1000, "R6 gap");
    apply({1'b1, 62'b0}, 4'b1111, "R6 top");
    apply(therm_of(20), 4'b1010, "after err");

    for (int k = 0; k < 300; k++) begin
      logic [TW-1:0] w;
      w = therm_of(int'($urandom_range(0, 63)));
      if ($urandom_range(0, 4) == 0) w[$urandom_range(0, TW-1)] ^= 1'b1;
      apply(w, 4'($urandom_range(0, 15)), "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule